// File: doc/BRIEF.md
# Virtualization Control-Field Entry Checker

This block keeps the three 32-bit execution-control vectors of a virtual machine (an asynchronous-event vector, a primary instruction-control vector and a secondary instruction-control vector). It also keeps the capability masks that say, for each bit, whether it must be 1 and whether it may be 1. Software loads all of these through a single register-write port. When a VM-entry request pulse arrives, every control bit is compared with its capability. One clock later the block returns a pass/fail result, a reason code naming the first vector that broke its rules, and the effective secondary vector.

Two capability sets are held for the asynchronous-event and primary vectors: a legacy set and a true set. A mode input selects between them at request time. In legacy mode a fixed group of historical default-1 bits is always enforced, whatever the legacy must-be-1 register holds. The secondary vector only takes effect when bit 31 of the primary vector is set. Otherwise it is treated as all zeros.

Top module: `vmctl_entry_check`

## Requirements
- R1: After reset, all three control registers read as 0 and `res_valid` is low. Each may-be-1 mask of the asynchronous-event and primary sets is all ones, each must-be-1 mask is 0, and the secondary may-be-1 mask is 0. With these contents an entry request fails with code 0 in legacy mode and passes in true mode.
- R2: A one-cycle pulse on `entry_req` produces a one-cycle pulse on `res_valid` on the next clock edge, and `res_valid` is low in every other cycle. The check uses the register contents as they stand before that edge.
- R3: A vector fails when one of its bits is 0 while the selected must-be-1 mask has that bit set.
- R4: A vector fails when one of its bits is 1 while the selected may-be-1 mask has that bit clear.
- R5: In legacy mode (`cap_true_mode` = 0), bits 1, 2 and 4 of the asynchronous-event vector must be 1, even if the legacy must-be-1 register does not demand them.
- R6: In legacy mode, bits 1, 4, 5, 6, 8, 13, 14, 15, 16 and 26 of the primary vector must be 1, even if the legacy must-be-1 register does not demand them.
- R7: In true mode (`cap_true_mode` = 1), only the written true-set masks apply, so the default-1 positions may be 0.
- R8: When primary bit 31 is 0, `res_sec_eff` is all zeros and the secondary vector cannot cause a failure. When bit 31 is 1, `res_sec_eff` equals the secondary register.
- R9: The secondary vector has no must-be-1 bits. Any effective secondary bit set outside the secondary may-be-1 mask fails entry with code 2.
- R10: If the selected primary may-be-1 mask has bit 31 clear, setting primary bit 31 fails entry with code 1.
- R11: `res_code` gives 0 for an asynchronous-event failure, 1 for a primary failure, 2 for a secondary failure and 3 for a pass. The vectors are checked in that priority order, and `res_pass` is high exactly when the code is 3.
- R12: Writes go to word addresses as follows:
  - 0: asynchronous-event control
  - 1: primary control
  - 2: secondary control
  - 3/4: asynchronous-event legacy must-be-1 / may-be-1
  - 5/6: asynchronous-event true must-be-1 / may-be-1
  - 7/8: primary legacy must-be-1 / may-be-1
  - 9/10: primary true must-be-1 / may-be-1
  - 11: secondary may-be-1

  Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| cap_true_mode | input | 1 | 0 selects legacy capability set, 1 the true set |
| entry_req | input | 1 | VM-entry check request pulse |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_pass | output | 1 | High when every vector is legal |
| res_code | output | 2 | Fail reason code or 3 for pass |
| res_sec_eff | output | 32 | Effective secondary control vector |

## Verification
The assertions assume that `entry_req` is never held high for two cycles in a row. They also assume that no register write and no change of `cap_true_mode` falls in the same cycle as a request, so the compared values are stable. The stimulus meets both assumptions: every request is a single-cycle pulse, issued only after all writes for that scenario have completed. The mode input is set together with the pulse and then held. A bench-side model computes the expected code from shadow copies of the written registers. Per-bit sweeps and pseudo-random vector sets exercise each priority level in both capability modes.

// File: rtl/vmctl_pkg.sv
// Package: shared register map, result codes and legacy default-1 masks
// for the virtualization control-field entry checker.
// Assumes a 32-bit control word; the masks below are sized to it.
package vmctl_pkg;

    localparam int CTL_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 12;

    // Word addresses of the writable registers.
    typedef enum logic [ADDR_W-1:0] {
        A_PIN_CTL    = 4'd0,
        A_PRIM_CTL   = 4'd1,
        A_SEC_CTL    = 4'd2,
        A_PIN_L_M1   = 4'd3,
        A_PIN_L_Y    = 4'd4,
        A_PIN_T_M1   = 4'd5,
        A_PIN_T_Y    = 4'd6,
        A_PRIM_L_M1  = 4'd7,
        A_PRIM_L_Y   = 4'd8,
        A_PRIM_T_M1  = 4'd9,
        A_PRIM_T_Y   = 4'd10,
        A_SEC_Y      = 4'd11
    } reg_addr_e;

    // Result codes, in check priority order.
    typedef enum logic [1:0] {
        FAIL_PIN  = 2'd0,
        FAIL_PRIM = 2'd1,
        FAIL_SEC  = 2'd2,
        ENTRY_OK  = 2'd3
    } entry_code_e;

    // Positions forced to 1 under the legacy capability set.
    localparam logic [CTL_W-1:0] PIN_DEF1  = 32'h0000_0016;
    localparam logic [CTL_W-1:0] PRIM_DEF1 = 32'h0401_E172;

    // Primary bit that enables the secondary vector.
    localparam int SEC_GATE_BIT = 31;

endpackage

// File: rtl/vmctl_regfile.sv
// Module: vmctl_regfile
// Holds the control and capability registers written through a plain
// address/data/enable port. Each register has its own reset value:
// controls and must-be-1 masks clear, may-be-1 masks of the two
// capability sets all ones, the secondary may-be-1 mask clear.
// Assumes addresses at or above NUM_REGS are unmapped and are ignored.
module vmctl_regfile
    import vmctl_pkg::*;
#(
    parameter int W      = CTL_W,
    parameter int AW     = ADDR_W,
    parameter int NREGS  = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  regs_o [NREGS]
);

    // Reset value for register index idx.
    function automatic logic [W-1:0] reset_value(input int idx);
        logic [W-1:0] v;
        case (idx)
            int'(A_PIN_L_Y), int'(A_PIN_T_Y),
            int'(A_PRIM_L_Y), int'(A_PRIM_T_Y): v = '1;
            default:                            v = '0;
        endcase
        return v;
    endfunction

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [W-1:0]  RST_VAL = reset_value(g);
        localparam logic [AW-1:0] MY_ADDR = AW'(g);
        logic [W-1:0] q;

        // Load on a matching write, restore reset value on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (wr_en && (wr_addr == MY_ADDR)) begin
                q <= wr_data;
            end
        end

        assign regs_o[g] = q;
    end

endmodule

// File: rtl/vmctl_cap_sel.sv
// Module: vmctl_cap_sel
// Chooses the legacy or true capability pair for one control vector.
// Under the legacy set the fixed default-1 positions are added to the
// must-be-1 mask whatever the register holds.
// Assumes true_mode is stable in the cycle of an entry request.
module vmctl_cap_sel #(
    parameter int           W    = 32,
    parameter logic [W-1:0] DEF1 = '0
) (
    input  logic         true_mode,
    input  logic [W-1:0] legacy_m1,
    input  logic [W-1:0] legacy_y,
    input  logic [W-1:0] true_m1,
    input  logic [W-1:0] true_y,
    output logic [W-1:0] m1_o,
    output logic [W-1:0] y_o
);

    // Select the active mask pair.
    always_comb begin
        if (true_mode) begin
            m1_o = true_m1;
            y_o  = true_y;
        end else begin
            m1_o = legacy_m1 | DEF1;
            y_o  = legacy_y;
        end
    end

endmodule

// File: rtl/vmctl_vec_check.sv
// Module: vmctl_vec_check
// Tests one control vector against its must-be-1 and may-be-1 masks.
// A bit is legal when it is 1 wherever must-be-1 is set and 0 wherever
// may-be-1 is clear. A bit that is in must-be-1 but not in may-be-1 can
// never be legal; that is a capability fault and simply fails.
module vmctl_vec_check #(
    parameter int W = 32
) (
    input  logic [W-1:0] ctl,
    input  logic [W-1:0] must1,
    input  logic [W-1:0] may1,
    output logic         ok_o
);

    logic [W-1:0] bad_bit;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Flag a bit that misses a required 1 or carries a forbidden 1.
        always_comb begin
            bad_bit[b] = (must1[b] && !ctl[b]) || (ctl[b] && !may1[b]);
        end
    end

    // Whole vector legal when no bit is flagged.
    always_comb begin
        ok_o = (bad_bit == '0);
    end

endmodule

// File: rtl/vmctl_entry_check.sv
// Module: vmctl_entry_check (top)
// Checks the three execution-control vectors on a VM-entry request and
// reports, one clock later, a pass flag, a priority-encoded reason code
// and the effective secondary vector.
// Assumes entry_req is a single-cycle pulse and that no write or mode
// change coincides with it; the check uses pre-edge register contents.
module vmctl_entry_check
    import vmctl_pkg::*;
#(
    parameter int           W         = CTL_W,
    parameter int           AW        = ADDR_W,
    parameter int           GATE_BIT  = SEC_GATE_BIT,
    parameter logic [W-1:0] PIN_D1    = PIN_DEF1,
    parameter logic [W-1:0] PRIM_D1   = PRIM_DEF1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          cap_true_mode,
    input  logic          entry_req,
    output logic          res_valid,
    output logic          res_pass,
    output logic [1:0]    res_code,
    output logic [W-1:0]  res_sec_eff
);

    localparam int NREGS = NUM_REGS;

    logic [W-1:0] regs [NREGS];
    logic [W-1:0] pin_q, prim_q, sec_q;
    logic [W-1:0] pin_m1, pin_y, prim_m1, prim_y;
    logic [W-1:0] sec_eff;
    logic         pin_ok, prim_ok, sec_ok;
    entry_code_e  code_d;

    vmctl_regfile #(
        .W     (W),
        .AW    (AW),
        .NREGS (NREGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    assign pin_q  = regs[A_PIN_CTL];
    assign prim_q = regs[A_PRIM_CTL];
    assign sec_q  = regs[A_SEC_CTL];

    vmctl_cap_sel #(.W(W), .DEF1(PIN_D1)) u_pin_cap (
        .true_mode (cap_true_mode),
        .legacy_m1 (regs[A_PIN_L_M1]),
        .legacy_y  (regs[A_PIN_L_Y]),
        .true_m1   (regs[A_PIN_T_M1]),
        .true_y    (regs[A_PIN_T_Y]),
        .m1_o      (pin_m1),
        .y_o       (pin_y)
    );

    vmctl_cap_sel #(.W(W), .DEF1(PRIM_D1)) u_prim_cap (
        .true_mode (cap_true_mode),
        .legacy_m1 (regs[A_PRIM_L_M1]),
        .legacy_y  (regs[A_PRIM_L_Y]),
        .true_m1   (regs[A_PRIM_T_M1]),
        .true_y    (regs[A_PRIM_T_Y]),
        .m1_o      (prim_m1),
        .y_o       (prim_y)
    );

    // Secondary vector only counts when the primary gate bit is set.
    always_comb begin
        sec_eff = prim_q[GATE_BIT] ? sec_q : '0;
    end

    vmctl_vec_check #(.W(W)) u_pin_chk (
        .ctl   (pin_q),
        .must1 (pin_m1),
        .may1  (pin_y),
        .ok_o  (pin_ok)
    );

    vmctl_vec_check #(.W(W)) u_prim_chk (
        .ctl   (prim_q),
        .must1 (prim_m1),
        .may1  (prim_y),
        .ok_o  (prim_ok)
    );

    vmctl_vec_check #(.W(W)) u_sec_chk (
        .ctl   (sec_eff),
        .must1 ('0),
        .may1  (regs[A_SEC_Y]),
        .ok_o  (sec_ok)
    );

    // Priority encode: async-event vector first, then primary, then secondary.
    always_comb begin
        if (!pin_ok) begin
            code_d = FAIL_PIN;
        end else if (!prim_ok) begin
            code_d = FAIL_PRIM;
        end else if (!sec_ok) begin
            code_d = FAIL_SEC;
        end else begin
            code_d = ENTRY_OK;
        end
    end

    // Strobe follows each request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= entry_req;
        end
    end

    // Capture the verdict and effective secondary vector on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pass    <= 1'b0;
            res_code    <= 2'(FAIL_PIN);
            res_sec_eff <= '0;
        end else if (entry_req) begin
            res_pass    <= (code_d == ENTRY_OK);
            res_code    <= 2'(code_d);
            res_sec_eff <= sec_eff;
        end
    end

    // ---------------- assertions ----------------

    p_req_gives_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_req |=> res_valid);

    p_valid_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_req |=> !res_valid);

    p_pass_matches_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_code == 2'(ENTRY_OK))));

    p_sec_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(prim_q[GATE_BIT])) |-> (res_sec_eff == '0));

    p_legacy_pin_def1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass && !$past(cap_true_mode))
            |-> (($past(pin_q) & PIN_D1) == PIN_D1));

    p_legacy_prim_def1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass && !$past(cap_true_mode))
            |-> (($past(prim_q) & PRIM_D1) == PRIM_D1));

    p_no_sec_support_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(pin_ok && prim_q[GATE_BIT] && !prim_y[GATE_BIT]))
            |-> (res_code == 2'(FAIL_PRIM)));

endmodule

// File: tb/vmctl_entry_check_bench.sv
`timescale 1ns/1ps
module vmctl_entry_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cap_true_mode = 1'b0;
    logic        entry_req = 1'b0;
    logic        res_valid, res_pass;
    logic [1:0]  res_code;
    logic [31:0] res_sec_eff;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] sh [12];
    logic [31:0] lfsr = 32'hACE1_1234;

    localparam logic [31:0] PIN_LEG  = 32'h0000_0016;
    localparam logic [31:0] PRIM_LEG = 32'h0401_E172;

    always #4 clk = ~clk;

    vmctl_entry_check u_vmctl_entry_check (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .cap_true_mode (cap_true_mode),
        .entry_req     (entry_req),
        .res_valid     (res_valid),
        .res_pass      (res_pass),
        .res_code      (res_code),
        .res_sec_eff   (res_sec_eff)
    );

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Expected reason code from the requirements and shadow registers.
    function automatic logic [1:0] exp_code(input logic tm);
        logic [31:0] pm1, py, qm1, qy, se;
        pm1 = tm ? sh[5] : (sh[3] | PIN_LEG);
        py  = tm ? sh[6] : sh[4];
        qm1 = tm ? sh[9] : (sh[7] | PRIM_LEG);
        qy  = tm ? sh[10] : sh[8];
        se  = sh[1][31] ? sh[2] : 32'h0;
        if (((sh[0] & pm1) != pm1) || ((sh[0] & ~py) != 0)) return 2'd0;
        if (((sh[1] & qm1) != qm1) || ((sh[1] & ~qy) != 0)) return 2'd1;
        if ((se & ~sh[11]) != 0) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        if (addr < 12) sh[addr] = data;
    endtask

    // Issue one request and compare every result field with the model.
    task automatic entry(input logic tm, input string req);
        logic [1:0]  ec;
        logic [31:0] es;
        ec = exp_code(tm);
        es = sh[1][31] ? sh[2] : 32'h0;
        @(negedge clk);
        cap_true_mode = tm;
        entry_req     = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        check(res_valid === 1'b1, {req, " R2 valid"}, 32'(res_valid), 32'd1);
        check(res_code === ec, {req, " R11 code"}, 32'(res_code), 32'(ec));
        check(res_pass === (ec == 2'd3), {req, " R11 pass"}, 32'(res_pass), 32'(ec == 2'd3));
        check(res_sec_eff === es, {req, " R8 sec_eff"}, res_sec_eff, es);
        @(negedge clk);
        check(res_valid === 1'b0, {req, " R2 single"}, 32'(res_valid), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) sh[i] = 32'h0;
        sh[4] = '1; sh[6] = '1; sh[8] = '1; sh[10] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, "R1 valid after reset", 32'(res_valid), 32'd0);

        // R1: defaults fail in legacy mode, pass in true mode.
        entry(1'b0, "R1 legacy defaults");
        check(res_code === 2'd0, "R1 legacy code", 32'(res_code), 32'd0);
        entry(1'b1, "R1 true defaults");
        check(res_code === 2'd3, "R1 true code", 32'(res_code), 32'd3);

        // R5/R6: default-1 sets enforced in legacy even with empty registers.
        wr(0, PIN_LEG & ~32'h4);
        entry(1'b0, "R5 pin bit2 missing");
        wr(0, PIN_LEG);
        entry(1'b0, "R5 pin ok, prim missing");
        wr(1, PRIM_LEG & ~(32'h1 << 26));
        entry(1'b0, "R6 prim bit26 missing");
        wr(1, PRIM_LEG);
        entry(1'b0, "R6 legacy pass");
        check(res_pass === 1'b1, "R6 legacy pass flag", 32'(res_pass), 32'd1);

        // R7: true mode ignores default-1 sets.
        wr(0, 32'h0); wr(1, 32'h0);
        entry(1'b1, "R7 true zero ok");
        entry(1'b0, "R7 same vectors legacy fail");

        // R3/R4: per-bit sweep on the async-event vector in true mode.
        for (int b = 0; b < 32; b++) begin
            wr(5, 32'h1 << b); wr(0, 32'h0);
            entry(1'b1, "R3 must1 bit clear");
            wr(0, 32'h1 << b);
            entry(1'b1, "R3 must1 bit set");
            wr(5, 32'h0); wr(6, ~(32'h1 << b));
            entry(1'b1, "R4 may1 forbidden bit");
            wr(6, 32'hFFFF_FFFF);
        end
        wr(0, 32'h0);

        // R8/R9: secondary gating and mask.
        wr(2, 32'hFFFF_FFFF); wr(11, 32'h0);
        entry(1'b1, "R8 gate off");
        wr(1, 32'h8000_0000);
        entry(1'b1, "R9 gate on illegal");
        wr(11, 32'h0000_00F0); wr(2, 32'h0000_0010);
        entry(1'b1, "R9 within mask");
        wr(2, 32'h0000_0100);
        entry(1'b1, "R9 outside mask");
        check(res_code === 2'd2, "R9 code", 32'(res_code), 32'd2);

        // R10: gate bit not allowed to be 1.
        wr(10, 32'h7FFF_FFFF);
        entry(1'b1, "R10 no secondary support");
        check(res_code === 2'd1, "R10 code", 32'(res_code), 32'd1);
        wr(10, 32'hFFFF_FFFF);

        // R11: priority when two vectors are bad.
        wr(6, 32'h0); wr(0, 32'h1); wr(10, 32'h0);
        entry(1'b1, "R11 pin over prim");
        check(res_code === 2'd0, "R11 priority", 32'(res_code), 32'd0);
        wr(6, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF);

        // R12: unmapped writes leave every register unchanged.
        for (int a = 12; a < 16; a++) wr(a, 32'hFFFF_FFFF);
        entry(1'b1, "R12 unmapped true");
        entry(1'b0, "R12 unmapped legacy");

        // Pseudo-random sweep covering all codes in both modes (R3 R4 R11).
        for (int it = 0; it < 150; it++) begin
            logic [31:0] r, f;
            for (int a = 3; a < 12; a++) begin
                r = next_rand();
                if (a == 3 || a == 5 || a == 7 || a == 9) wr(a, r & next_rand() & next_rand());
                else wr(a, r | next_rand());
            end
            f = (next_rand()[2:0] == 3'd0) ? (32'h1 << next_rand()[4:0]) : 32'h0;
            wr(0, ((next_rand()[0] ? sh[5] : (sh[3] | PIN_LEG)) | (next_rand() & sh[6])) ^ f);
            f = (next_rand()[2:0] == 3'd0) ? (32'h1 << next_rand()[4:0]) : 32'h0;
            wr(1, ((next_rand()[0] ? sh[9] : (sh[7] | PRIM_LEG)) | (next_rand() & sh[8] & sh[10])) ^ f);
            f = (next_rand()[1:0] == 2'd0) ? (32'h1 << next_rand()[4:0]) : 32'h0;
            wr(2, (next_rand() & sh[11]) ^ f);
            entry(1'b0, "R11 random legacy");
            entry(1'b1, "R11 random true");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule